// File: doc/BRIEF.md
# DMA Bus Ownership Arbiter

This block lives on the processor side of a shared bus and passes bus mastership to a single external DMA device. The device asks for the bus with a request line. The arbiter answers with a grant only at a bus cycle boundary, and never while the processor holds its lock input for an atomic read-modify-write sequence. Because the boundary is a bus cycle and not an instruction, the grant may fall between two bus cycles of one instruction.

Once the device acknowledges the grant, the arbiter keeps the processor stalled and enables snooping of the bus for cache coherence. When the device signals release, the arbiter drops the grant, pulses a release acknowledge for one cycle and then lets the processor resume. A device that never acknowledges loses the grant after a bounded number of cycles. After any ownership or timeout, the request must go low for at least one clock before the device can be served again.

Top module: `dma_own_arb`

## Requirements
- R1: During reset and in the first cycle after it, `bus_grant`, `snoop_en`, `rel_ack` and `cpu_stall` are all low.
- R2: When the arbiter is idle and, at a rising clock edge, `dev_req` is high, `cyc_busy` is low and `lock_in` is low, `bus_grant` goes high after that edge. In no other situation does `bus_grant` rise.
- R3: If `dev_ack` is high at an edge while the grant is pending, `snoop_en` is high from the next cycle on and stays high until release is acknowledged. `cpu_stall` is high in every cycle in which `bus_grant` or `rel_ack` is high.
- R4: If `dev_rel` is high at an edge while the device owns the bus, then in the next cycle `bus_grant` and `snoop_en` are low and `rel_ack` is high for exactly one cycle. `cpu_stall` is low in the cycle after that.
- R5: While `lock_in` is high, no grant is issued. A request held through the lock is granted in the cycle after the first edge at which the lock is low and the bus cycle has ended.
- R6: If `dev_ack` stays low, `bus_grant` stays high for exactly `TIMEOUT` cycles (default 16) and then drops, with no `rel_ack`.
- R7: After a release or a timeout, no new grant is issued until `dev_req` has been sampled low at least once.
- R8: While `cyc_busy` is high, a pending request is not granted. The grant follows the first edge at which `cyc_busy` is low, even if further bus cycles of the same instruction come after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_req | input | 1 | Bus request from the DMA device |
| cyc_busy | input | 1 | High while a processor bus cycle is in progress |
| lock_in | input | 1 | High during a locked read-modify-write sequence |
| dev_ack | input | 1 | Grant acknowledge from the device |
| dev_rel | input | 1 | Bus release from the device |
| bus_grant | output | 1 | Bus grant to the device |
| snoop_en | output | 1 | Enables snooping of the bus address and data lines |
| rel_ack | output | 1 | One-cycle acknowledge of the release |
| cpu_stall | output | 1 | Holds off processor bus cycles |

## Verification
Directed sequences hold the request across a busy bus cycle, then across a lock, which separates the boundary rule from the lock rule. A run with the request held high through release shows that the request must drop before it is served again, and a run without acknowledge pins the timeout length to the exact cycle. Several thousand cycles of seeded random request, busy, lock, acknowledge and release patterns are then compared each cycle against a reference model in the bench. These random cycles reach the overlaps that the directed cases leave out, such as an acknowledge on the last cycle before timeout or a lock rising while the grant is already out.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_GNT  = 3'd1,
      ST_OWN  = 3'd2,
      ST_REL  = 3'd3,
      ST_WAIT = 3'd4
   } arb_st_t;
endpackage

// File: rtl/arb_grant_timer.sv
module arb_grant_timer #(
   parameter int TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expire_o
);
   localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT + 1) : 1;

   generate
      if (TIMEOUT == 0) begin : g_no_timer
         assign expire_o = 1'b0;
      end else begin : g_timer
         logic [CW-1:0] cnt_q;
         localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (!run_i) cnt_q <= '0;
            else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
         end

         assign expire_o = run_i && (cnt_q == LAST);

         AST_TMO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            run_i |-> (cnt_q < CW'(TIMEOUT))); // R6
      end
   endgenerate
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
   import dma_arb_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_i,
   input  logic    busy_i,
   input  logic    lock_i,
   input  logic    ack_i,
   input  logic    rel_i,
   input  logic    expire_i,
   output arb_st_t state_o
);
   arb_st_t state_q, state_d;
   logic    serve_ok;

   assign serve_ok = req_i && !busy_i && !lock_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (serve_ok) state_d = ST_GNT;
         ST_GNT: begin
            if (ack_i)         state_d = ST_OWN;
            else if (expire_i) state_d = ST_WAIT;
         end
         ST_OWN:  if (rel_i)  state_d = ST_REL;
         ST_REL:              state_d = ST_WAIT;
         ST_WAIT: if (!req_i) state_d = ST_IDLE;
         default:             state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   AST_GNT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && busy_i) |=> (state_q == ST_IDLE)); // R8
   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && lock_i) |=> (state_q == ST_IDLE)); // R5
   AST_REL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REL) |=> (state_q == ST_WAIT)); // R4
   AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && req_i) |=> (state_q == ST_WAIT)); // R7
endmodule

// File: rtl/arb_out_map.sv
module arb_out_map
   import dma_arb_pkg::*;
(
   input  arb_st_t state_i,
   output logic    grant_o,
   output logic    snoop_o,
   output logic    rel_ack_o,
   output logic    stall_o
);
   always_comb begin
      grant_o   = (state_i == ST_GNT) || (state_i == ST_OWN);
      snoop_o   = (state_i == ST_OWN);
      rel_ack_o = (state_i == ST_REL);
      stall_o   = grant_o || rel_ack_o;
   end
endmodule

// File: rtl/dma_own_arb.sv
module dma_own_arb
   import dma_arb_pkg::*;
#(
   parameter int TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dev_req,
   input  logic cyc_busy,
   input  logic lock_in,
   input  logic dev_ack,
   input  logic dev_rel,
   output logic bus_grant,
   output logic snoop_en,
   output logic rel_ack,
   output logic cpu_stall
);
   generate
      if (TIMEOUT < 0 || TIMEOUT > 65535) begin : g_bad_param
         $error("TIMEOUT out of range");
      end
   endgenerate

   arb_st_t st;
   logic    expire;
   logic    in_gnt;

   assign in_gnt = (st == ST_GNT);

   arb_grant_timer #(.TIMEOUT(TIMEOUT)) u_timer (
      .clk(clk), .rst_n(rst_n), .run_i(in_gnt), .expire_o(expire)
   );

   arb_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .req_i(dev_req), .busy_i(cyc_busy),
      .lock_i(lock_in), .ack_i(dev_ack), .rel_i(dev_rel),
      .expire_i(expire), .state_o(st)
   );

   arb_out_map u_map (
      .state_i(st), .grant_o(bus_grant), .snoop_o(snoop_en),
      .rel_ack_o(rel_ack), .stall_o(cpu_stall)
   );

   AST_SNOOP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(snoop_en) |-> $past(bus_grant && dev_ack)); // R3
   AST_GRANT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_grant) |-> $past(dev_req && !cyc_busy && !lock_in)); // R2
   AST_STALL_COVER: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_grant || rel_ack) |-> cpu_stall); // R3
endmodule

// File: tb/dma_own_arb_test.sv
module dma_own_arb_test;
   localparam int TMO = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dev_req = 0, cyc_busy = 0, lock_in = 0, dev_ack = 0, dev_rel = 0;
   logic bus_grant, snoop_en, rel_ack, cpu_stall;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int m_st = 0;
   int m_cnt = 0;

   always #10 clk = ~clk;

   dma_own_arb #(.TIMEOUT(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .cyc_busy(cyc_busy),
      .lock_in(lock_in), .dev_ack(dev_ack), .dev_rel(dev_rel),
      .bus_grant(bus_grant), .snoop_en(snoop_en), .rel_ack(rel_ack),
      .cpu_stall(cpu_stall)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int model_next(int st, int cnt, logic rq, logic bz,
                                     logic lk, logic ak, logic rl);
      case (st)
         0: return (rq && !bz && !lk) ? 1 : 0;
         1: return ak ? 2 : ((cnt == TMO - 1) ? 4 : 1);
         2: return rl ? 3 : 2;
         3: return 4;
         default: return rq ? 4 : 0;
      endcase
   endfunction

   task automatic compare_model();
      chk("R2 grant",   bus_grant, (m_st == 1 || m_st == 2));
      chk("R3 snoop",   snoop_en,  (m_st == 2));
      chk("R4 rel_ack", rel_ack,   (m_st == 3));
      chk("R3 stall",   cpu_stall, (m_st >= 1 && m_st <= 3));
   endtask

   task automatic step(input logic rq, input logic bz, input logic lk,
                       input logic ak, input logic rl);
      int nx;
      @(negedge clk);
      dev_req = rq; cyc_busy = bz; lock_in = lk; dev_ack = ak; dev_rel = rl;
      nx = model_next(m_st, m_cnt, rq, bz, lk, ak, rl);
      m_cnt = (nx == 1 && m_st == 1) ? m_cnt + 1 : 0;
      m_st = nx;
      @(posedge clk);
      #2;
      compare_model();
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int gcount;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk("R1 grant", bus_grant, 0); chk("R1 stall", cpu_stall, 0);
      chk("R1 snoop", snoop_en, 0);  chk("R1 rel_ack", rel_ack, 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #2;
      chk("R1 grant after reset", bus_grant, 0);

      // R8: request during busy bus cycles is held off
      step(1, 1, 0, 0, 0); chk("R8 busy holds grant", bus_grant, 0);
      step(1, 1, 0, 0, 0); chk("R8 busy holds grant", bus_grant, 0);
      step(1, 0, 0, 0, 0); chk("R8 grant at boundary", bus_grant, 1);
      step(1, 1, 0, 0, 0); chk("R8 grant kept across next cycle", bus_grant, 1);
      // R3 ack -> snoop
      step(1, 0, 0, 1, 0); chk("R3 snoop on ack", snoop_en, 1);
      step(1, 0, 0, 1, 0); chk("R3 snoop held", snoop_en, 1);
      // R4 release
      step(1, 0, 0, 1, 1); chk("R4 rel_ack", rel_ack, 1); chk("R4 grant drop", bus_grant, 0);
      chk("R4 snoop drop", snoop_en, 0);
      step(1, 0, 0, 0, 0); chk("R4 rel_ack single", rel_ack, 0); chk("R4 stall low", cpu_stall, 0);
      // R7: request still high -> no grant
      step(1, 0, 0, 0, 0); chk("R7 no regrant", bus_grant, 0);
      step(0, 0, 0, 0, 0); chk("R7 low cycle", bus_grant, 0);
      step(1, 0, 0, 0, 0); chk("R7 regrant after low", bus_grant, 1);
      step(1, 0, 0, 1, 0);
      step(0, 0, 0, 1, 1);
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);

      // R5 lock holds off, pending request served after lock drops
      step(1, 0, 1, 0, 0); chk("R5 lock blocks", bus_grant, 0);
      step(1, 0, 1, 0, 0); chk("R5 lock blocks", bus_grant, 0);
      step(1, 1, 0, 0, 0); chk("R5 busy after lock", bus_grant, 0);
      step(1, 0, 0, 0, 0); chk("R5 granted after lock", bus_grant, 1);

      // R6 timeout: no ack
      gcount = 1;
      for (int i = 0; i < TMO + 3; i++) begin
         step(0, 0, 0, 0, 0);
         if (bus_grant) gcount++;
         chk("R6 no rel_ack on timeout", rel_ack, 0);
      end
      chk("R6 grant length", (gcount == TMO), 1'b1);
      if (gcount != TMO) $display("FAIL R6: actual %0d expected %0d cycles", gcount, TMO);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic rq, bz, lk, ak, rl;
         rq = ($urandom % 4) != 0;
         bz = ($urandom % 2) != 0;
         lk = ($urandom % 5) == 0;
         ak = ($urandom % 4) == 0;
         rl = ($urandom % 3) == 0;
         step(rq, bz, lk, ak, rl);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule